// File: doc/BRIEF.md
# Configurable Trigger Router

This block carries single-bit event triggers from producer peripherals to consumer peripherals. It holds two kinds of routing. Mux lanes are arranged in groups: every mux output picks any one input of its own group, so a single input can fan out to several outputs. Pair lanes are fixed: pair input k can only reach pair output k, and only when that lane is enabled.

Every output, of either kind, has its own enable, polarity invert, level or edge mode and a software trigger. All trigger inputs are first brought into the clock domain by a two-flop synchroniser. Settings arrive through a simple write-only register port. Each write takes either the configuration word of one output or a software trigger pulse for one output.

Address layout: the top address bit selects the region, 0 for configuration and 1 for software trigger. The low bits are the output index. Mux output o of group g has index g*GRP_OUT+o. Pair lane k has index N_GROUPS*GRP_OUT+k. Configuration word: bits [3:0] select, of which only the low log2(GRP_IN) bits are used; bit 4 enable; bit 5 invert; bit 6 edge mode (0 = level). A software trigger write pulses when data bit 0 is 1.

Top module: `trig_router`

## Requirements
- R1: While reset is high, every output is low on the next clock. After reset, every output is disabled, non-inverted and in level mode, with select 0.
- R2: An enabled, level-mode mux output g*GRP_OUT+o follows synchronised input g*GRP_IN+sel. A change on that input shows at the output after three rising clock edges.
- R3: Several outputs of one group can select the same input at once. A select value only reaches inputs of the output's own group.
- R4: An enabled, level-mode pair lane k follows pair input k, with the same three-edge latency, and no other input.
- R5: A disabled output stays low, whatever its input, invert setting or software trigger.
- R6: With invert (bit 5) set, the output carries the complement of the routed input, still subject to enable.
- R7: In edge mode (bit 6), each rising edge of the post-invert signal gives a single one-cycle high pulse. A signal that stays high gives no further pulse.
- R8: A software trigger write (top address bit 1, data bit 0 = 1) is ORed with the routed input for one cycle, before invert and edge detection. An enabled level-mode output shows it as a one-cycle pulse on the clock after the write.
- R9: A configuration write changes the output on the clock after the edge that takes the write. The output for the write edge itself still follows the old setting.
- R10: The block ignores each of these: software trigger writes with data bit 0 = 0; writes to indices at or above the number of outputs; select bits above log2(GRP_IN).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_trig_in | input | N_GROUPS*GRP_IN | Mux group trigger inputs, GRP_IN per group |
| pair_trig_in | input | N_PAIRS | Fixed-pair trigger inputs |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Region bit (top) and output index |
| cfg_wdata | input | 8 | Configuration word or software trigger bit |
| mux_trig_out | output | N_GROUPS*GRP_OUT | Mux group trigger outputs |
| pair_trig_out | output | N_PAIRS | Fixed-pair trigger outputs |

## Verification
An input change reaches an output three rising edges after it is driven: two synchroniser stages, then the output register. A configuration write or software trigger shows one edge after the write edge. The bench drives on falling edges and samples on falling edges, so it counts these edges exactly. It checks the cycle before each result is due as well as the cycle it lands. A behavioural model advances once per rising edge and is compared with both output buses at every falling edge, under directed and random traffic.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;
  // configuration word field positions (software-visible, decoded by the register file)
  localparam int FLD_SEL_LSB = 0;
  localparam int FLD_EN      = 4;
  localparam int FLD_INV     = 5;
  localparam int FLD_EDGE    = 6;
  localparam int FLD_SWTRIG  = 0;
  localparam int CFG_DATA_W  = 8;

  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_EDGE  = 1'b1
  } trig_mode_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/trig_cfg_regs.sv
module trig_cfg_regs
  import trig_route_pkg::*;
#(
  parameter int N_OUT  = 40,
  parameter int N_MUX  = 32,
  parameter int SEL_W  = 3,
  parameter int ADDR_W = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CFG_DATA_W-1:0]     wdata,
  output logic [N_MUX-1:0][SEL_W-1:0] sel_q,
  output logic [N_OUT-1:0]          en_q,
  output logic [N_OUT-1:0]          inv_q,
  output logic [N_OUT-1:0]          edge_q,
  output logic [N_OUT-1:0]          sw_q
);
  localparam int IDX_W = ADDR_W - 1;

  logic [IDX_W-1:0] idx;
  logic             sw_region;
  logic             unused_wdata_bits;

  assign idx       = addr[IDX_W-1:0];
  assign sw_region = addr[ADDR_W-1];
  assign unused_wdata_bits = ^{wdata[CFG_DATA_W-1], wdata[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      en_q   <= '0;
      inv_q  <= '0;
      edge_q <= '0;
      sw_q   <= '0;
    end else begin
      sw_q <= '0;
      for (int i = 0; i < N_OUT; i++) begin
        if (we && (idx == IDX_W'(i))) begin
          if (!sw_region) begin
            en_q[i]   <= wdata[FLD_EN];
            inv_q[i]  <= wdata[FLD_INV];
            edge_q[i] <= wdata[FLD_EDGE];
          end else if (wdata[FLD_SWTRIG]) begin
            sw_q[i] <= 1'b1;
          end
        end
      end
      for (int i = 0; i < N_MUX; i++) begin
        if (we && !sw_region && (idx == IDX_W'(i)))
          sel_q[i] <= wdata[FLD_SEL_LSB +: SEL_W];
      end
    end
  end
endmodule

// File: rtl/trig_out_stage.sv
module trig_out_stage
  import trig_route_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic src,
  input  logic sw,
  input  logic en,
  input  logic inv,
  input  logic edge_mode,
  output logic q
);
  logic x;
  logic prev_q;

  assign x = (src | sw) ^ inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      q      <= 1'b0;
    end else begin
      prev_q <= x;
      if (!en)
        q <= 1'b0;
      else if (trig_mode_e'(edge_mode) == MODE_EDGE)
        q <= x & ~prev_q;
      else
        q <= x;
    end
  end
endmodule

// File: rtl/trig_router.sv
module trig_router
  import trig_route_pkg::*;
#(
  parameter int N_GROUPS = 4,
  parameter int GRP_IN   = 8,
  parameter int GRP_OUT  = 8,
  parameter int N_PAIRS  = 8,
  parameter int ADDR_W   = $clog2(N_GROUPS*GRP_OUT + N_PAIRS) + 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_GROUPS*GRP_IN-1:0]   mux_trig_in,
  input  logic [N_PAIRS-1:0]           pair_trig_in,
  input  logic                         cfg_we,
  input  logic [ADDR_W-1:0]            cfg_addr,
  input  logic [CFG_DATA_W-1:0]        cfg_wdata,
  output logic [N_GROUPS*GRP_OUT-1:0]  mux_trig_out,
  output logic [N_PAIRS-1:0]           pair_trig_out
);
  localparam int MUX_IN  = N_GROUPS * GRP_IN;
  localparam int MUX_OUT = N_GROUPS * GRP_OUT;
  localparam int N_OUT   = MUX_OUT + N_PAIRS;
  localparam int SEL_W   = $clog2(GRP_IN);

  logic [MUX_IN-1:0]               mux_s;
  logic [N_PAIRS-1:0]              pair_s;
  logic [MUX_OUT-1:0][SEL_W-1:0]   sel_v;
  logic [N_OUT-1:0]                en_v, inv_v, edge_v, sw_v, src_v, out_q;

  trig_sync #(.W(MUX_IN)) u_sync_mux (
    .clk(clk), .rst(rst), .d(mux_trig_in), .q(mux_s)
  );

  trig_sync #(.W(N_PAIRS)) u_sync_pair (
    .clk(clk), .rst(rst), .d(pair_trig_in), .q(pair_s)
  );

  trig_cfg_regs #(
    .N_OUT(N_OUT), .N_MUX(MUX_OUT), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .sel_q(sel_v), .en_q(en_v), .inv_q(inv_v), .edge_q(edge_v), .sw_q(sw_v)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_group
    logic [GRP_IN-1:0] grp_in;
    assign grp_in = mux_s[g*GRP_IN +: GRP_IN];
    for (genvar o = 0; o < GRP_OUT; o++) begin : g_out
      assign src_v[g*GRP_OUT + o] = grp_in[sel_v[g*GRP_OUT + o]];
    end
  end

  for (genvar k = 0; k < N_PAIRS; k++) begin : g_pair
    assign src_v[MUX_OUT + k] = pair_s[k];
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_stage
    trig_out_stage u_stage (
      .clk(clk), .rst(rst), .src(src_v[i]), .sw(sw_v[i]), .en(en_v[i]),
      .inv(inv_v[i]), .edge_mode(edge_v[i]), .q(out_q[i])
    );
  end

  assign mux_trig_out  = out_q[MUX_OUT-1:0];
  assign pair_trig_out = out_q[N_OUT-1:MUX_OUT];
endmodule

// File: rtl/trig_router_chk.sv
module trig_router_chk #(
  parameter int N_OUT = 40
) (
  input logic             clk,
  input logic             rst,
  input logic [N_OUT-1:0] out_q,
  input logic [N_OUT-1:0] en_v,
  input logic [N_OUT-1:0] edge_v,
  input logic [N_OUT-1:0] sw_v
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (out_q == '0)); // R1

  AST_ONE_SW_PULSE: assert property (@(posedge clk) disable iff (rst)
    $countones(sw_v) <= 1); // R8

  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
      !en_v[i] |=> !out_q[i]); // R5
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      (out_q[i] && edge_v[i]) |=> !out_q[i]); // R7
  end
endmodule

bind trig_router trig_router_chk #(.N_OUT(N_GROUPS*GRP_OUT + N_PAIRS)) u_chk (
  .clk(clk), .rst(rst), .out_q(out_q), .en_v(en_v), .edge_v(edge_v), .sw_v(sw_v)
);

// File: tb/trig_router_bench.sv
module trig_router_bench;
  localparam int NG = 4, GI = 8, GO = 8, NP = 8;
  localparam int MIN = NG*GI, MOUT = NG*GO, NTOT = MOUT + NP, AW = 7;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst = 1'b1;
  logic [MIN-1:0] mux_in = '0;
  logic [NP-1:0]  pair_in = '0;
  logic           we = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [7:0]     wdata = '0;
  wire  [MOUT-1:0] mux_out;
  wire  [NP-1:0]   pair_out;

  trig_router u_trig_router (
    .clk(clk), .rst(rst), .mux_trig_in(mux_in), .pair_trig_in(pair_in),
    .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata),
    .mux_trig_out(mux_out), .pair_trig_out(pair_out)
  );

  int n_checks = 0, n_err = 0;
  string cur_req = "R1";
  bit cmp_on = 0;

  task automatic chk(input string req, input logic [NTOT-1:0] act, input logic [NTOT-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural reference model, one step per rising edge
  bit [MIN-1:0] m_ms1, m_ms2;
  bit [NP-1:0]  m_ps1, m_ps2;
  int m_sel [NTOT];
  bit m_en [NTOT], m_inv [NTOT], m_edge [NTOT], m_sw [NTOT], m_prev [NTOT];
  bit [NTOT-1:0] m_out;
  bit n_out [NTOT], n_prev [NTOT];

  always @(posedge clk) begin
    if (rst) begin
      m_ms1 = '0; m_ms2 = '0; m_ps1 = '0; m_ps2 = '0; m_out = '0;
      for (int i = 0; i < NTOT; i++) begin
        m_sel[i] = 0; m_en[i] = 0; m_inv[i] = 0; m_edge[i] = 0; m_sw[i] = 0; m_prev[i] = 0;
      end
    end else begin
      for (int i = 0; i < NTOT; i++) begin
        bit s, x;
        s = (i < MOUT) ? m_ms2[(i/GO)*GI + m_sel[i]] : m_ps2[i-MOUT];
        x = (s | m_sw[i]) ^ m_inv[i];
        n_out[i]  = m_en[i] ? (m_edge[i] ? (x & !m_prev[i]) : x) : 1'b0;
        n_prev[i] = x;
      end
      for (int i = 0; i < NTOT; i++) begin
        m_out[i] = n_out[i]; m_prev[i] = n_prev[i]; m_sw[i] = 0;
      end
      m_ms2 = m_ms1; m_ms1 = mux_in; m_ps2 = m_ps1; m_ps1 = pair_in;
      if (we && int'(addr[5:0]) < NTOT) begin
        if (!addr[6]) begin
          if (int'(addr[5:0]) < MOUT) m_sel[addr[5:0]] = int'(wdata[2:0]);
          m_en[addr[5:0]] = wdata[4]; m_inv[addr[5:0]] = wdata[5]; m_edge[addr[5:0]] = wdata[6];
        end else if (wdata[0]) begin
          m_sw[addr[5:0]] = 1;
        end
      end
    end
  end

  always @(negedge clk) if (cmp_on) chk(cur_req, {pair_out, mux_out}, m_out);

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs low in reset", {pair_out, mux_out}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs low after reset", {pair_out, mux_out}, '0);
    cmp_on = 1;

    cur_req = "R5";
    mux_in = '1; pair_in = '1;
    repeat (4) @(negedge clk);
    chk("R5 disabled outputs stay low", {pair_out, mux_out}, '0);
    mux_in = '0; pair_in = '0;
    repeat (4) @(negedge clk);

    cur_req = "R2";
    wr(7'd0, 8'h13); wr(7'd1, 8'h13); wr(7'd10, 8'h13);
    mux_in = 32'h8;
    repeat (2) @(negedge clk);
    chk("R2 not yet after two edges", 40'(mux_out[0]), 40'd0);
    @(negedge clk);
    chk("R2 routed after three edges", 40'(mux_out[0]), 40'd1);
    chk("R3 fan-out to second output", 40'(mux_out[1]), 40'd1);
    chk("R3 group1 output ignores group0 input", 40'(mux_out[10]), 40'd0);
    mux_in = 32'h800;
    repeat (3) @(negedge clk);
    chk("R3 group1 output uses own input", 40'(mux_out[10]), 40'd1);

    cur_req = "R9";
    mux_in = 32'h808;
    repeat (3) @(negedge clk);
    wr(7'd1, 8'h00);
    chk("R9 old setting on write edge", 40'(mux_out[1]), 40'd1);
    @(negedge clk);
    chk("R9 new setting one edge later", 40'(mux_out[1]), 40'd0);

    cur_req = "R6";
    wr(7'd2, 8'h30);
    @(negedge clk);
    chk("R6 inverted low input reads high", 40'(mux_out[2]), 40'd1);

    cur_req = "R7";
    wr(7'd4, 8'h55);
    mux_in = mux_in | 32'h20;
    repeat (3) @(negedge clk);
    chk("R7 edge pulse high", 40'(mux_out[4]), 40'd1);
    @(negedge clk);
    chk("R7 pulse lasts one cycle", 40'(mux_out[4]), 40'd0);
    repeat (3) @(negedge clk);
    chk("R7 held input no repeat", 40'(mux_out[4]), 40'd0);
    mux_in = mux_in & ~32'h20;
    repeat (4) @(negedge clk);

    cur_req = "R8";
    wr(7'd6, 8'h17);
    wr(7'd70, 8'h01);
    chk("R8 not yet on write cycle", 40'(mux_out[6]), 40'd0);
    @(negedge clk);
    chk("R8 software pulse level mode", 40'(mux_out[6]), 40'd1);
    @(negedge clk);
    chk("R8 software pulse ends", 40'(mux_out[6]), 40'd0);
    wr(7'd68, 8'h01);
    @(negedge clk);
    chk("R8 software pulse edge mode", 40'(mux_out[4]), 40'd1);
    @(negedge clk);
    chk("R8 edge-mode software pulse ends", 40'(mux_out[4]), 40'd0);

    cur_req = "R10";
    wr(7'd70, 8'hFE);
    repeat (2) @(negedge clk);
    chk("R10 software write with bit0 clear ignored", 40'(mux_out[6]), 40'd0);
    wr(7'd109, 8'h01); wr(7'd45, 8'h7F);
    repeat (2) @(negedge clk);
    chk("R10 out-of-range index ignored", {pair_out, mux_out}, m_out);
    wr(7'd7, 8'h1B);
    mux_in = 32'h8;
    repeat (3) @(negedge clk);
    chk("R10 upper select bit ignored", 40'(mux_out[7]), 40'd1);

    cur_req = "R4";
    wr(7'd32, 8'h10);
    pair_in = 8'h03;
    repeat (3) @(negedge clk);
    chk("R4 pair lane follows own input", 40'(pair_out), 40'h01);
    wr(7'd34, 8'h50);
    pair_in = 8'h07;
    repeat (3) @(negedge clk);
    chk("R4 pair edge lane pulses", 40'(pair_out), 40'h05);

    cur_req = "random traffic";
    for (int c = 0; c < 3000; c++) begin
      mux_in = $urandom(); pair_in = 8'($urandom());
      if (($urandom() & 3) == 0) wr(7'($urandom()), 8'($urandom()));
      else @(negedge clk);
    end

    cur_req = "R1";
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears outputs", {pair_out, mux_out}, '0);
    finish_run();
  end
endmodule